// File: doc/BRIEF.md
# I2C Byte Transfer Sequencer

This block moves one I2C transfer unit through a data shift register, one bit for each strobe from an external SCL clock generator. Software sets a 3-bit bit-count field and an interface enable through a control write. A write to the data register then loads the shift register and starts a transfer. The current MSB sets the open-drain SDA drive, and the received line value enters at the LSB. When the programmed number of bits has moved, the block raises a one-cycle interrupt request and sets its pending flag.

The block also keeps a bus-busy flag, which is set by a detected START and cleared by a detected STOP. It keeps a sticky arbitration-lost flag, which is set from an external detector. A detected START clears the count field, so the address byte that follows always moves as a full 8 bits. Clearing the enable releases both bus lines and forces the flags to a fixed state. While the enable is clear, writes to the data register have no effect.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset, the outputs read as follows: `pend`=1, `busy`=0, `arb_lost`=0, `irq`=0, `sda_drive_low`=0, `scl_enable`=0, `cnt_q`=0.
- R2: A count field of 1 to 7 moves exactly that many bits. `irq` stays 0 until the strobe that shifts the last bit, and strobes received while no transfer is running have no effect.
- R3: A count field of 0 moves 8 bits.
- R4: Bits move MSB first. While a transfer runs, `sda_drive_low` equals the inverse of `shreg[7]`. On each strobe, `shreg` shifts left and the `sda_in` value enters bit 0.
- R5: `irq` is a one-cycle pulse. It is high in the cycle after the clock edge that shifts the last bit, and `pend` is 1 in that same cycle.
- R6: A data write while enabled loads `shreg`, clears `pend` and the arbitration-lost flag, and starts a transfer using the count field held at that moment.
- R7: A detected START (`start_det`) clears the count field to 0. It overrides the count part of a control write in the same cycle, but the enable part of that write still takes effect.
- R8: The control word carries the count in bits 2:0 and the enable in bit 3. While the enable is 0, `sda_drive_low`=0 and `scl_enable`=0.
- R9: While the enable is 0, `pend`=1, `busy`=0 and `arb_lost`=0. Clearing the enable during a transfer aborts it without an `irq`.
- R10: While the enable is 0, data writes are ignored: `shreg`, `pend` and `irq` do not change.
- R11: While enabled, `start_det` sets `busy` and `stop_det` clears it.
- R12: `arb_lost_in` sets `arb_lost` while enabled. While `arb_lost` is 1, `sda_drive_low` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 4 | Control word: [2:0] bit count, [3] enable |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 8 | Data word to load into the shift register |
| bit_strobe | input | 1 | One-cycle strobe per SCL bit from the clock generator |
| sda_in | input | 1 | Sampled SDA line value |
| start_det | input | 1 | START condition detected |
| stop_det | input | 1 | STOP condition detected |
| arb_lost_in | input | 1 | Arbitration loss reported by the detector |
| sda_drive_low | output | 1 | Open-drain SDA pull-down request |
| scl_enable | output | 1 | Clock generator may drive SCL |
| shreg | output | 8 | Shift register contents |
| cnt_q | output | 3 | Current bit-count field |
| pend | output | 1 | Transfer pending or complete flag |
| busy | output | 1 | Bus busy flag |
| arb_lost | output | 1 | Arbitration lost flag |
| irq | output | 1 | Transfer-complete interrupt pulse |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a detected START and a control write that programs a non-zero count. The bench drives both in one cycle and reads `cnt_q` back as 0 and `busy` as 1. It then confirms that the next transfer takes 8 strobes.

The second pair is a disable write during a running transfer. The bench checks that the flags take their forced values, that `irq` never pulses, and that a data write made afterwards leaves `shreg` unchanged.

// File: rtl/i2c_xfer_pkg.sv
package i2c_xfer_pkg;
  // A zero count field means a full data word; otherwise the value itself.
  function automatic int unsigned bits_for(input int unsigned code,
                                           input int unsigned full);
    return (code == 0) ? full : code;
  endfunction

  // Next shift register value: shift left, new bit at the LSB.
  function automatic logic [7:0] shift_in(input logic [7:0] cur, input logic b);
    return {cur[6:0], b};
  endfunction
endpackage

// File: rtl/xfer_ctrl_reg.sv
module xfer_ctrl_reg #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [CNT_W:0]   ctrl_wdata,
  input  logic             start_det,
  output logic             en_q,
  output logic             en_nx,
  output logic [CNT_W-1:0] cnt_q
);
  localparam int EN_BIT = CNT_W;

  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    en_nx  = ctrl_we ? ctrl_wdata[EN_BIT] : en_q;
    cnt_nx = cnt_q;
    if (ctrl_we)   cnt_nx = ctrl_wdata[CNT_W-1:0];
    if (start_det) cnt_nx = '0;   // START wins over the written count
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q  <= en_nx;
      cnt_q <= cnt_nx;
    end
  end

  AST_START_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/xfer_shift_eng.sv
module xfer_shift_eng
  import i2c_xfer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_q,
  input  logic              en_nx,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_wdata,
  input  logic              bit_strobe,
  input  logic              sda_in,
  input  logic              al_q,
  output logic [DATA_W-1:0] shreg,
  output logic              active,
  output logic              load_ev,
  output logic              done_ev,
  output logic              sda_drive_low
);
  localparam int LEFT_W = $clog2(DATA_W + 1);

  logic [LEFT_W-1:0] left_q;
  logic              step_ev;

  assign load_ev = data_we && en_q && en_nx;
  assign step_ev = active && bit_strobe && en_nx && !load_ev;
  assign done_ev = step_ev && (left_q == LEFT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      active <= 1'b0;
      left_q <= '0;
    end else if (!en_nx) begin
      active <= 1'b0;
      left_q <= '0;
    end else if (load_ev) begin
      shreg  <= data_wdata;
      active <= 1'b1;
      left_q <= LEFT_W'(bits_for(int'(cnt_q), DATA_W));
    end else if (step_ev) begin
      shreg  <= {shreg[DATA_W-2:0], sda_in};
      left_q <= left_q - LEFT_W'(1);
      if (done_ev) active <= 1'b0;
    end
  end

  assign sda_drive_low = en_q && active && !al_q && !shreg[DATA_W-1];

  AST_ACTIVE_HAS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (left_q != '0)); // R2
  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (active && shreg == $past(data_wdata))); // R6
  AST_SDA_RELEASED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !sda_drive_low); // R8
  AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && data_we) |=> $stable(shreg)); // R10
endmodule

// File: rtl/xfer_status.sv
module xfer_status (
  input  logic clk,
  input  logic rst_n,
  input  logic en_q,
  input  logic en_nx,
  input  logic load_ev,
  input  logic done_ev,
  input  logic start_det,
  input  logic stop_det,
  input  logic arb_lost_in,
  output logic pend,
  output logic busy,
  output logic al_q,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b1;
      busy <= 1'b0;
      al_q <= 1'b0;
      irq  <= 1'b0;
    end else if (!en_nx) begin
      pend <= 1'b1;
      busy <= 1'b0;
      al_q <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= done_ev;
      if (load_ev)      pend <= 1'b0;
      else if (done_ev) pend <= 1'b1;
      if (start_det)     busy <= 1'b1;
      else if (stop_det) busy <= 1'b0;
      if (arb_lost_in)  al_q <= 1'b1;
      else if (load_ev) al_q <= 1'b0;
    end
  end

  AST_OFF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (pend && !busy && !al_q)); // R9
  AST_DONE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> (irq && pend)); // R5
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R5
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CNT_W:0]    ctrl_wdata,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_wdata,
  input  logic              bit_strobe,
  input  logic              sda_in,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              arb_lost_in,
  output logic              sda_drive_low,
  output logic              scl_enable,
  output logic [DATA_W-1:0] shreg,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              pend,
  output logic              busy,
  output logic              arb_lost,
  output logic              irq
);
  logic en_q, en_nx, active, load_ev, done_ev;

  xfer_ctrl_reg #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .start_det(start_det), .en_q(en_q), .en_nx(en_nx), .cnt_q(cnt_q)
  );

  xfer_shift_eng #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .en_nx(en_nx), .cnt_q(cnt_q),
    .data_we(data_we), .data_wdata(data_wdata), .bit_strobe(bit_strobe),
    .sda_in(sda_in), .al_q(arb_lost), .shreg(shreg), .active(active),
    .load_ev(load_ev), .done_ev(done_ev), .sda_drive_low(sda_drive_low)
  );

  xfer_status u_stat (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .en_nx(en_nx),
    .load_ev(load_ev), .done_ev(done_ev), .start_det(start_det),
    .stop_det(stop_det), .arb_lost_in(arb_lost_in),
    .pend(pend), .busy(busy), .al_q(arb_lost), .irq(irq)
  );

  assign scl_enable = en_q;

  AST_SCL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !scl_enable); // R8
  AST_AL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> !sda_drive_low); // R12
endmodule

// File: tb/tb_i2c_xfer_seq.sv
module tb_i2c_xfer_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_we = 0, data_we = 0, bit_strobe = 0, sda_in = 0;
  logic start_det = 0, stop_det = 0, arb_lost_in = 0;
  logic [3:0] ctrl_wdata = '0;
  logic [7:0] data_wdata = '0;
  logic sda_drive_low, scl_enable, pend, busy, arb_lost, irq;
  logic [7:0] shreg;
  logic [2:0] cnt_q;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  i2c_xfer_seq dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .bit_strobe(bit_strobe),
    .sda_in(sda_in), .start_det(start_det), .stop_det(stop_det),
    .arb_lost_in(arb_lost_in), .sda_drive_low(sda_drive_low),
    .scl_enable(scl_enable), .shreg(shreg), .cnt_q(cnt_q), .pend(pend),
    .busy(busy), .arb_lost(arb_lost), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic en, input logic [2:0] c);
    ctrl_we = 1; ctrl_wdata = {en, c}; tick(); ctrl_we = 0;
  endtask

  task automatic wr_data(input logic [7:0] d);
    data_we = 1; data_wdata = d; tick(); data_we = 0;
  endtask

  // Runs one transfer of nb bits and checks irq timing, MSB-first order.
  task automatic run_xfer(input string req, input logic [2:0] code,
                          input logic [7:0] w, input logic [7:0] rx);
    int nb;
    logic [7:0] exp;
    nb = (code == 0) ? 8 : int'(code);
    wr_ctrl(1'b1, code);
    wr_data(w);
    exp = w;
    chk("R6", "pend after load", {31'b0, pend}, 0);
    for (int i = 0; i < nb; i++) begin
      chk("R4", "sda drive", {31'b0, sda_drive_low}, {31'b0, ~exp[7]});
      bit_strobe = 1; sda_in = rx[i]; tick(); bit_strobe = 0;
      exp = {exp[6:0], rx[i]};
      if (i < nb - 1) begin
        chk(req, "irq early", {31'b0, irq}, 0);
        tick();  // an idle cycle between strobes
        chk(req, "irq idle", {31'b0, irq}, 0);
      end
    end
    chk("R5", "irq at end", {31'b0, irq}, 1);
    chk("R5", "pend at end", {31'b0, pend}, 1);
    chk("R4", "shreg after shift", {24'b0, shreg}, {24'b0, exp});
    tick();
    chk("R5", "irq one cycle", {31'b0, irq}, 0);
    bit_strobe = 1; tick(); bit_strobe = 0;  // stray strobe ignored
    chk("R2", "stray strobe shreg", {24'b0, shreg}, {24'b0, exp});
    chk("R2", "stray strobe irq", {31'b0, irq}, 0);
  endtask

  task automatic t_reset();
    chk("R1", "pend", {31'b0, pend}, 1);
    chk("R1", "busy", {31'b0, busy}, 0);
    chk("R1", "arb_lost", {31'b0, arb_lost}, 0);
    chk("R1", "irq", {31'b0, irq}, 0);
    chk("R1", "sda", {31'b0, sda_drive_low}, 0);
    chk("R1", "scl", {31'b0, scl_enable}, 0);
    chk("R1", "cnt", {29'b0, cnt_q}, 0);
  endtask

  task automatic t_start_collision();
    ctrl_we = 1; ctrl_wdata = 4'b1101; start_det = 1; tick();
    ctrl_we = 0; start_det = 0;
    chk("R7", "cnt after START+write", {29'b0, cnt_q}, 0);
    chk("R7", "enable taken", {31'b0, scl_enable}, 1);
    chk("R11", "busy on START", {31'b0, busy}, 1);
    wr_data(8'h3C);
    for (int i = 0; i < 7; i++) begin
      bit_strobe = 1; sda_in = 1; tick(); bit_strobe = 0;
      chk("R7", "irq before 8th", {31'b0, irq}, 0);
    end
    bit_strobe = 1; sda_in = 0; tick(); bit_strobe = 0;
    chk("R7", "irq at 8th", {31'b0, irq}, 1);
    chk("R7", "shreg", {24'b0, shreg}, 32'hFE);
    stop_det = 1; tick(); stop_det = 0;
    chk("R11", "busy after STOP", {31'b0, busy}, 0);
  endtask

  task automatic t_arb();
    wr_ctrl(1'b1, 3'd0);
    wr_data(8'h00);
    chk("R12", "sda driving", {31'b0, sda_drive_low}, 1);
    arb_lost_in = 1; tick(); arb_lost_in = 0;
    chk("R12", "arb_lost set", {31'b0, arb_lost}, 1);
    chk("R12", "sda released", {31'b0, sda_drive_low}, 0);
    wr_data(8'h80);
    chk("R6", "arb cleared by load", {31'b0, arb_lost}, 0);
  endtask

  task automatic t_disable();
    logic [7:0] held;
    wr_ctrl(1'b1, 3'd4);
    start_det = 1; arb_lost_in = 1; tick(); start_det = 0; arb_lost_in = 0;
    wr_data(8'h11);
    bit_strobe = 1; sda_in = 1; tick(); bit_strobe = 0;
    wr_ctrl(1'b0, 3'd4);  // abort mid-transfer
    chk("R9", "pend forced", {31'b0, pend}, 1);
    chk("R9", "busy forced", {31'b0, busy}, 0);
    chk("R9", "arb forced", {31'b0, arb_lost}, 0);
    chk("R8", "sda released", {31'b0, sda_drive_low}, 0);
    chk("R8", "scl off", {31'b0, scl_enable}, 0);
    held = shreg;
    wr_data(8'hA5);
    chk("R10", "shreg kept", {24'b0, shreg}, {24'b0, held});
    chk("R10", "pend kept", {31'b0, pend}, 1);
    for (int i = 0; i < 4; i++) begin
      bit_strobe = 1; tick(); bit_strobe = 0;
      chk("R9", "no irq after abort", {31'b0, irq}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1; tick();
    t_reset();
    run_xfer("R2", 3'd3, 8'h4B, 8'b0000_0101);
    run_xfer("R2", 3'd1, 8'h80, 8'b0000_0001);
    run_xfer("R3", 3'd0, 8'h96, 8'b1010_0110);
    run_xfer("R2", 3'd7, 8'h5A, 8'b0110_0011);
    t_start_collision();
    t_arb();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule